// File: doc/BRIEF.md
# Parallel Graphic-LCD Write Cycle Engine

This block performs single write transfers on an 8-bit parallel bus for a graphic LCD built from two controller halves. Each half has its own select line. A requester offers a transfer over a valid/ready handshake. The transfer names the target half, the kind of write (display data or a controller instruction) and the byte to write. The engine latches the request and drives the selects, the data/instruction line and the byte onto the bus. It then produces one timed enable strobe, waits out a recovery interval, flags completion, and enforces a short quiet gap before it accepts the next request.

Four intervals are given as parameters in nanoseconds: setup before the strobe, strobe width, recovery after the strobe, and the gap after completion. Each interval is turned into clock cycles from a clock-frequency parameter, rounded up, and is never shorter than one cycle. Only writes are performed, so the read/write line stays at write and the data bus is always driven.

Top module: `lcd_write_engine`

## Requirements
- R1: With `req_half`=0 a transfer drives `lcd_sel_a`=1 and `lcd_sel_b`=0. With `req_half`=1 it drives `lcd_sel_a`=0 and `lcd_sel_b`=1. Outside the setup, strobe and recovery phases both selects are 0, and the two are never high together.
- R2: `lcd_dsel` is 1 for a data write (`req_is_data`=1) and 0 for an instruction write (`req_is_data`=0). `lcd_db` carries `req_byte`.
- R3: `lcd_rnw` is always 0 and `lcd_db_oe` is always 1.
- R4: The selects, `lcd_dsel` and the byte are on the bus for exactly SETUP_CYC cycles before `lcd_en` rises. SETUP_CYC = ceil(SETUP_NS*CLK_MHZ/1000), with a minimum of 1, which gives 250 at the defaults.
- R5: `lcd_en` stays high for exactly PULSE_CYC consecutive cycles. PULSE_CYC is derived from PULSE_NS in the same way, which gives 250 at the defaults.
- R6: After `lcd_en` falls, recovery lasts RECOV_CYC cycles (1250 at the defaults). `xfer_done` is a single-cycle pulse in the last recovery cycle, while the selects are still driven.
- R7: After the `xfer_done` cycle, `req_ready` stays low for GAP_CYC cycles (250 at the defaults) and then returns high.
- R8: `req_ready` is high only while the engine is idle. A request presented while `req_ready` is low is ignored and never appears on the bus.
- R9: The selects, `lcd_dsel` and `lcd_db` stay unchanged from the first setup cycle to the last recovery cycle.
- R10: After reset, `req_ready`=1, `lcd_en`=0, both selects are 0 and `xfer_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted on this edge if valid |
| req_half | input | 1 | Target half: 0 = first, 1 = second |
| req_is_data | input | 1 | 1 = data write, 0 = instruction write |
| req_byte | input | 8 | Byte to write |
| xfer_done | output | 1 | One-cycle pulse at the end of recovery |
| lcd_sel_a | output | 1 | Select for the first half |
| lcd_sel_b | output | 1 | Select for the second half |
| lcd_dsel | output | 1 | Data/instruction select |
| lcd_rnw | output | 1 | Read/write line, held at write (0) |
| lcd_en | output | 1 | Enable strobe |
| lcd_db | output | 8 | Data bus |
| lcd_db_oe | output | 1 | Data bus output enable, held at 1 |

## Verification
A phase register or interval counter that goes wrong appears at once as a strobe that starts, ends or is followed by completion one or more cycles off. It can also appear as `req_ready` returning before the gap has run out. All of these are visible within a single transfer, about 2000 cycles at the defaults. A request latch that is reloaded while busy shows up as the byte or the selects changing in the middle of a transfer, in the same cycle as the stray request. A wrongly decoded half or mode shows up as the wrong select or `lcd_dsel` from the first setup cycle onward.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

    localparam int unsigned BUS_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_RECOV  = 3'd3,
        PH_GAP    = 3'd4
    } phase_e;

    typedef struct packed {
        logic             half;
        logic             is_data;
        logic [BUS_W-1:0] data;
    } lcd_req_t;

    // Interval in ns to clock cycles, rounded up, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/lcdw_interval_timer.sv
module lcdw_interval_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/lcdw_phase_ctrl.sv
module lcdw_phase_ctrl
    import lcdw_pkg::*;
#(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned SETUP_CYC = 1,
    parameter int unsigned PULSE_CYC = 1,
    parameter int unsigned RECOV_CYC = 1,
    parameter int unsigned GAP_CYC   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             expired,
    output phase_e           phase,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CYC - 1);

    phase_e nxt;

    always_comb begin
        nxt      = phase;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (phase)
            PH_IDLE: if (start) begin
                nxt = PH_SETUP; tmr_load = 1'b1; tmr_val = SETUP_LD;
            end
            PH_SETUP: if (expired) begin
                nxt = PH_STROBE; tmr_load = 1'b1; tmr_val = PULSE_LD;
            end
            PH_STROBE: if (expired) begin
                nxt = PH_RECOV; tmr_load = 1'b1; tmr_val = RECOV_LD;
            end
            PH_RECOV: if (expired) begin
                nxt = PH_GAP; tmr_load = 1'b1; tmr_val = GAP_LD;
            end
            PH_GAP: if (expired) begin
                nxt = PH_IDLE;
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end
endmodule

// File: rtl/lcdw_pin_driver.sv
module lcdw_pin_driver
    import lcdw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  lcd_req_t         req,
    input  logic             release_sel,
    output logic             sel_a,
    output logic             sel_b,
    output logic             dsel,
    output logic [BUS_W-1:0] db
);
    lcd_req_t held;
    logic     active;

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= '0;
            active <= 1'b0;
        end else if (capture) begin
            held   <= req;
            active <= 1'b1;
        end else if (release_sel) begin
            active <= 1'b0;
        end
    end

    assign sel_a = active & ~held.half;
    assign sel_b = active &  held.half;
    assign dsel  = held.is_data;
    assign db    = held.data;
endmodule

// File: rtl/lcd_write_engine.sv
module lcd_write_engine
    import lcdw_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 250,
    parameter int unsigned SETUP_NS = 1000,
    parameter int unsigned PULSE_NS = 1000,
    parameter int unsigned RECOV_NS = 5000,
    parameter int unsigned GAP_NS   = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_half,
    input  logic       req_is_data,
    input  logic [7:0] req_byte,
    output logic       xfer_done,
    output logic       lcd_sel_a,
    output logic       lcd_sel_b,
    output logic       lcd_dsel,
    output logic       lcd_rnw,
    output logic       lcd_en,
    output logic [7:0] lcd_db,
    output logic       lcd_db_oe
);
    localparam int unsigned SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_MHZ);
    localparam int unsigned PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_MHZ);
    localparam int unsigned RECOV_CYC = ns_to_cycles(RECOV_NS, CLK_MHZ);
    localparam int unsigned GAP_CYC   = ns_to_cycles(GAP_NS, CLK_MHZ);
    localparam int unsigned MAX_CYC   = max4(SETUP_CYC, PULSE_CYC, RECOV_CYC, GAP_CYC);
    localparam int unsigned CNT_W     = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    phase_e           phase;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             expired;
    logic             start;
    lcd_req_t         req;

    assign req_ready = (phase == PH_IDLE);
    assign start     = req_valid & req_ready;
    assign req       = '{half: req_half, is_data: req_is_data, data: req_byte};
    assign xfer_done = (phase == PH_RECOV) & expired;
    assign lcd_en    = (phase == PH_STROBE);
    assign lcd_rnw   = 1'b0;
    assign lcd_db_oe = 1'b1;

    lcdw_phase_ctrl #(
        .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
        .RECOV_CYC(RECOV_CYC), .GAP_CYC(GAP_CYC)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .expired(expired),
        .phase(phase), .tmr_load(tmr_load), .tmr_val(tmr_val)
    );

    lcdw_interval_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(expired)
    );

    lcdw_pin_driver u_pins (
        .clk(clk), .rst(rst), .capture(start), .req(req), .release_sel(xfer_done),
        .sel_a(lcd_sel_a), .sel_b(lcd_sel_b), .dsel(lcd_dsel), .db(lcd_db)
    );
endmodule

// File: rtl/lcdw_checker.sv
module lcdw_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       xfer_done,
    input logic       lcd_sel_a,
    input logic       lcd_sel_b,
    input logic       lcd_dsel,
    input logic       lcd_en,
    input logic [7:0] lcd_db
);
    logic sel_any;
    assign sel_any = lcd_sel_a | lcd_sel_b;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lcd_sel_a, lcd_sel_b})); // R1

    AST_EN_UNDER_SEL: assert property (@(posedge clk) disable iff (rst)
        lcd_en |-> sel_any); // R5

    AST_EN_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_en) |-> $past(sel_any)); // R4

    AST_DONE_IN_RECOV: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> (sel_any && !lcd_en)); // R6

    AST_DONE_THEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> (!req_ready && !sel_any)); // R7

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!sel_any && !lcd_en && !xfer_done)); // R8

    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
        (sel_any && $past(sel_any)) |->
            ($stable(lcd_db) && $stable(lcd_dsel) && $stable(lcd_sel_a))); // R9
endmodule

bind lcd_write_engine lcdw_checker u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .xfer_done(xfer_done),
    .lcd_sel_a(lcd_sel_a), .lcd_sel_b(lcd_sel_b), .lcd_dsel(lcd_dsel),
    .lcd_en(lcd_en), .lcd_db(lcd_db)
);

// File: tb/tb_lcd_write_engine.sv
module tb_lcd_write_engine;
    localparam int SETUP_EXP = 250;
    localparam int PULSE_EXP = 250;
    localparam int RECOV_EXP = 1250;
    localparam int GAP_EXP   = 250;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_half = 1'b0;
    logic       req_is_data = 1'b0;
    logic [7:0] req_byte = 8'h00;
    logic       xfer_done;
    logic       lcd_sel_a, lcd_sel_b, lcd_dsel, lcd_rnw, lcd_en, lcd_db_oe;
    logic [7:0] lcd_db;

    int tests = 0;
    int fails = 0;
    int seen  = 0;
    int sent  = 0;
    logic [9:0] expq[$];

    always #2 clk = ~clk;

    lcd_write_engine dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_half(req_half), .req_is_data(req_is_data), .req_byte(req_byte),
        .xfer_done(xfer_done), .lcd_sel_a(lcd_sel_a), .lcd_sel_b(lcd_sel_b),
        .lcd_dsel(lcd_dsel), .lcd_rnw(lcd_rnw), .lcd_en(lcd_en),
        .lcd_db(lcd_db), .lcd_db_oe(lcd_db_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: waits for idle, offers one request, then holds a stray request while busy.
    task automatic send(input logic half, input logic is_data, input logic [7:0] b);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        expq.push_back({half, is_data, b});
        sent++;
        req_valid = 1'b1; req_half = half; req_is_data = is_data; req_byte = b;
        @(negedge clk);
        // R8: stray request while busy must be ignored
        req_half = ~half; req_is_data = ~is_data; req_byte = ~b;
        repeat (20) @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: pops the expected item when a transfer appears and measures phases.
    initial begin : monitor
        forever begin
            logic [9:0] e;
            int s, p, r, g, bad;
            @(negedge clk);
            if (!rst && (lcd_sel_a || lcd_sel_b)) begin
                e = expq.pop_front();
                s = 0; p = 0; r = 0; g = 0; bad = 0;
                chk(lcd_sel_a == !e[9] && lcd_sel_b == e[9], "R1", {lcd_sel_a, lcd_sel_b}, {!e[9], e[9]});
                chk(lcd_dsel == e[8], "R2 dsel", lcd_dsel, e[8]);
                chk(lcd_db == e[7:0], "R2 byte", lcd_db, e[7:0]);
                while ((lcd_sel_a || lcd_sel_b) && !lcd_en) begin
                    s++;
                    if ({lcd_sel_b, lcd_dsel, lcd_db} != e || lcd_rnw || !lcd_db_oe) bad++;
                    @(negedge clk);
                end
                chk(s == SETUP_EXP, "R4 setup", s, SETUP_EXP);
                while (lcd_en) begin
                    p++;
                    if ({lcd_sel_b, lcd_dsel, lcd_db} != e || !(lcd_sel_a ^ lcd_sel_b) || lcd_rnw) bad++;
                    @(negedge clk);
                end
                chk(p == PULSE_EXP, "R5 pulse", p, PULSE_EXP);
                while (!xfer_done && r < 5000) begin
                    r++;
                    if ({lcd_sel_b, lcd_dsel, lcd_db} != e || !(lcd_sel_a ^ lcd_sel_b)) bad++;
                    @(negedge clk);
                end
                r++;
                chk(r == RECOV_EXP && (lcd_sel_a ^ lcd_sel_b), "R6 recovery", r, RECOV_EXP);
                chk(bad == 0, "R9 R3 stability", bad, 0);
                @(negedge clk);
                chk(!xfer_done, "R6 done single", xfer_done, 0);
                while (!req_ready && g < 5000) begin
                    g++;
                    if (lcd_sel_a || lcd_sel_b || lcd_en) bad++;
                    @(negedge clk);
                end
                chk(g == GAP_EXP, "R7 gap", g, GAP_EXP);
                chk(bad == 0, "R8 quiet while busy", bad, 0);
                seen++;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", seen, sent);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(req_ready && !lcd_en && !lcd_sel_a && !lcd_sel_b && !xfer_done, "R10",
            {req_ready, lcd_en, lcd_sel_a, lcd_sel_b, xfer_done}, 5'b10000);
        chk(!lcd_rnw && lcd_db_oe, "R3", {lcd_rnw, lcd_db_oe}, 2'b01);
        send(1'b0, 1'b1, 8'hA5);
        send(1'b1, 1'b0, 8'h3F);
        send(1'b0, 1'b0, 8'hB8);
        send(1'b1, 1'b1, 8'h00);
        send(1'b1, 1'b1, 8'hFF);
        send(1'b0, 1'b1, 8'h5A);
        while (seen < sent) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(expq.size() == 0 && req_ready, "R8 no extra transfer", expq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule